// File: doc/BRIEF.md
# Chained Serial Status Link Interface

This block shifts a frame of status bits onto a daisy-chained sideband link and captures the frame arriving from the upstream node. Start and end strobes mark the frame boundaries: a start seen on a rising link-clock edge lets the node begin shifting, and the node raises its end strobe while the final bit of its frame is on the data output. In single-originator mode the node restarts from its own end strobe and ignores the external start. The frame length is a parameter. All logic runs on the system clock. The link clock is handled as a level whose edges are detected in the system-clock domain.

One configuration bit selects whether the node sources the link clock and a slow 0.5 Hz blink clock, or receives both from inputs. When it sources them, the link clock comes from a divider with an 8-bit divide field, and the blink clock comes from a counter sized by the system clock frequency. The captured frame is presented in parallel with a one-cycle valid pulse. Configuration arrives as plain input ports.

Top module: `status_chain_link`

## Requirements
- R1: While reset is held, and on the first cycle after it, `link_clk_out`, `blink_clk_out`, `dout`, `end_out`, `rx_valid` and `rx_frame` are all 0.
- R2: With `cfg_clk_src`=1 the node drives `link_clk_out` as a square wave. It is low after reset, and each high or low level lasts `cfg_clk_div`+1 system clock cycles.
- R3: With `cfg_clk_src`=0, `link_clk_out` and `blink_clk_out` stay 0, the shifter is timed by `link_clk_in`, and `blink_clk_sel` follows `blink_clk_in`.
- R4: With `cfg_clk_src`=1, `blink_clk_out` toggles every `SYS_HZ` system clock cycles, giving a 0.5 Hz clock, and `blink_clk_sel` equals it.
- R5: With `cfg_single`=0, a frame starts only when `start_in` is 1 at a rising link edge while the node is idle. With no start, `dout` stays 0 and no frame is captured.
- R6: Each frame drives `tx_frame` most significant bit first, one bit per falling link edge, beginning on the falling edge after the start. `din` is sampled on each following rising edge, and the first sampled bit lands in `rx_frame[FRAME_BITS-1]`.
- R7: `end_out` is 1 from the falling edge that drives `tx_frame[0]` until the next falling edge, and 0 at all other times.
- R8: After the last bit is sampled, `rx_valid` pulses for exactly one cycle with the captured frame on `rx_frame`. `rx_frame` then holds until the next capture.
- R9: With `cfg_single`=1, `start_in` has no effect. The first frame starts at the first rising link edge, and each later frame restarts at the rising edge where `end_out` is 1, so frames repeat every `FRAME_BITS` link periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clk_src | input | 1 | 1: node sources link and blink clocks; 0: node receives them |
| cfg_clk_div | input | DIV_W | Link clock divide value; each level lasts value+1 cycles |
| cfg_single | input | 1 | Single-originator mode: own end strobe acts as start |
| link_clk_in | input | 1 | Received link clock |
| link_clk_out | output | 1 | Generated link clock (0 when receiving) |
| blink_clk_in | input | 1 | Received blink clock |
| blink_clk_out | output | 1 | Generated 0.5 Hz blink clock (0 when receiving) |
| blink_clk_sel | output | 1 | Blink clock in use by this node |
| start_in | input | 1 | Start strobe from the chain |
| end_out | output | 1 | End strobe, high during the last driven bit |
| dout | output | 1 | Serial data output |
| din | input | 1 | Serial data input |
| tx_frame | input | FRAME_BITS | Parallel frame to send, latched at frame start |
| rx_frame | output | FRAME_BITS | Last captured frame |
| rx_valid | output | 1 | One-cycle pulse when rx_frame is updated |

## Verification
The assertions assume that the divide field, the clock-source bit and the mode bit stay steady within a frame. They also assume that a received link clock holds each level for at least three system cycles, so that the synchroniser and edge detector see each edge once. The stimulus keeps to this: it resets the block before every change of clock source, changes the divide value only between captures, and drives the received link clock with levels of eight system cycles. Captures are judged only after a full frame has been started under the new settings.

// File: rtl/slk_pkg.sv
package slk_pkg;

  // System cycles spent in each level of the generated link clock.
  function automatic int unsigned link_half(input int unsigned div);
    return div + 1;
  endfunction

  // System cycles per blink level: one second, for a 2 s (0.5 Hz) period.
  function automatic int unsigned blink_half(input int unsigned sys_hz);
    return sys_hz;
  endfunction

  // Bits needed to count 0 .. n-1.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/slk_linkclk.sv
module slk_linkclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic [DIV_W-1:0] div,
  input  logic             lclk_in,
  output logic             gen_q,
  output logic             rise_p,
  output logic             fall_p
);

  logic [DIV_W-1:0] cnt;
  logic [1:0]       sync_q;
  logic             lvl;
  logic             prev_q;

  // Divider: gen_q toggles when the count reaches the divide value.
  always_ff @(posedge clk) begin
    if (!rst_n || !src_en) begin
      cnt   <= '0;
      gen_q <= 1'b0;
    end else if (cnt >= div) begin
      cnt   <= '0;
      gen_q <= ~gen_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Two-flop synchroniser for the received clock.
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], lclk_in};
  end

  assign lvl = src_en ? gen_q : sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise_p = lvl & ~prev_q;
  assign fall_p = ~lvl & prev_q;

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(div) |-> cnt <= div);

  p_level_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(gen_q));

  p_gen_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |=> !gen_q);

endmodule

// File: rtl/slk_blink.sv
module slk_blink #(
  parameter int unsigned SYS_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic blink_q
);
  import slk_pkg::*;

  localparam int unsigned HALF = blink_half(SYS_HZ);
  localparam int unsigned BW   = cnt_bits(HALF);
  localparam logic [BW-1:0] LAST = BW'(HALF - 1);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt     <= '0;
      blink_q <= 1'b0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      blink_q <= ~blink_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_blink_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  p_blink_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(blink_q));

endmodule

// File: rtl/slk_shifter.sv
module slk_shifter #(
  parameter int unsigned N = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_p,
  input  logic         fall_p,
  input  logic         single,
  input  logic         start_in,
  input  logic [N-1:0] tx_frame,
  input  logic         din,
  output logic         dout,
  output logic         end_out,
  output logic [N-1:0] rx_frame,
  output logic         rx_valid
);
  import slk_pkg::*;

  localparam int unsigned CW = cnt_bits(N + 1);
  localparam logic [CW-1:0] FULL = CW'(N);
  localparam logic [CW-1:0] LASTB = CW'(N - 1);

  logic          active;
  logic          started;
  logic [CW-1:0] drv_cnt;
  logic [CW-1:0] smp_cnt;
  logic [N-1:0]  txsh;
  logic [N-1:0]  rxsh;

  // Named events for the assertions.
  logic start_eff;
  logic smp_evt;
  logic last_smp;
  logic arm_evt;

  assign start_eff = single ? (end_out | ~started) : start_in;
  assign smp_evt   = rise_p && active && (smp_cnt != drv_cnt);
  assign last_smp  = smp_evt && (smp_cnt == LASTB);
  assign arm_evt   = rise_p && start_eff && (!active || last_smp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      started  <= 1'b0;
      drv_cnt  <= '0;
      smp_cnt  <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      dout     <= 1'b0;
      end_out  <= 1'b0;
      rx_frame <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!single) started <= 1'b0;
      if (fall_p) begin
        if (active && drv_cnt != FULL) begin
          dout    <= txsh[N-1];
          txsh    <= txsh << 1;
          end_out <= (drv_cnt == LASTB);
          drv_cnt <= drv_cnt + 1'b1;
        end else begin
          dout    <= 1'b0;
          end_out <= 1'b0;
        end
      end
      if (smp_evt) begin
        rxsh    <= {rxsh[N-2:0], din};
        smp_cnt <= smp_cnt + 1'b1;
      end
      if (last_smp) begin
        rx_frame <= {rxsh[N-2:0], din};
        rx_valid <= 1'b1;
        active   <= 1'b0;
      end
      if (arm_evt) begin
        active  <= 1'b1;
        started <= 1'b1;
        txsh    <= tx_frame;
        drv_cnt <= '0;
        smp_cnt <= '0;
      end
    end
  end

  p_valid_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_valid_follows_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(end_out));

  p_single_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (single && arm_evt && started) |-> end_out);

  p_counts_ordered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_cnt <= drv_cnt) && (drv_cnt <= FULL));

endmodule

// File: rtl/status_chain_link.sv
module status_chain_link #(
  parameter int unsigned FRAME_BITS = 36,
  parameter int          DIV_W      = 8,
  parameter int unsigned SYS_HZ     = 100_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_clk_src,
  input  logic [DIV_W-1:0]      cfg_clk_div,
  input  logic                  cfg_single,
  input  logic                  link_clk_in,
  output logic                  link_clk_out,
  input  logic                  blink_clk_in,
  output logic                  blink_clk_out,
  output logic                  blink_clk_sel,
  input  logic                  start_in,
  output logic                  end_out,
  output logic                  dout,
  input  logic                  din,
  input  logic [FRAME_BITS-1:0] tx_frame,
  output logic [FRAME_BITS-1:0] rx_frame,
  output logic                  rx_valid
);

  logic gen_q;
  logic rise_p;
  logic fall_p;
  logic blink_q;

  slk_linkclk #(.DIV_W(DIV_W)) u_lclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_en  (cfg_clk_src),
    .div     (cfg_clk_div),
    .lclk_in (link_clk_in),
    .gen_q   (gen_q),
    .rise_p  (rise_p),
    .fall_p  (fall_p)
  );

  slk_blink #(.SYS_HZ(SYS_HZ)) u_blink (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_clk_src),
    .blink_q (blink_q)
  );

  slk_shifter #(.N(FRAME_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .single   (cfg_single),
    .start_in (start_in),
    .tx_frame (tx_frame),
    .din      (din),
    .dout     (dout),
    .end_out  (end_out),
    .rx_frame (rx_frame),
    .rx_valid (rx_valid)
  );

  assign link_clk_out  = cfg_clk_src & gen_q;
  assign blink_clk_out = cfg_clk_src & blink_q;
  assign blink_clk_sel = cfg_clk_src ? blink_q : blink_clk_in;

  p_rx_edge_tied_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rise_p));

endmodule

// File: tb/sim_status_chain_link.sv
module sim_status_chain_link;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 12;
  localparam int SHZ  = 8;
  localparam int EXTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_clk_src = 1'b0;
  logic [7:0] cfg_clk_div = 8'd0;
  logic cfg_single = 1'b0;
  logic link_clk_in = 1'b0;
  logic blink_clk_in = 1'b0;
  logic start_in = 1'b0;
  logic loop_en = 1'b0;
  logic din_drv = 1'b0;
  logic [N-1:0] tx_frame = '0;
  logic link_clk_out, blink_clk_out, blink_clk_sel, end_out, dout, rx_valid, din;
  logic [N-1:0] rx_frame;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int cyc = 0;
  int vtime = 0;
  logic [N-1:0] last_rx = '0;

  assign din = loop_en ? dout : din_drv;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n && rx_valid) begin
    vcount++; last_rx = rx_frame; vtime = cyc;
  end

  status_chain_link #(.FRAME_BITS(N), .DIV_W(8), .SYS_HZ(SHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_clk_src(cfg_clk_src), .cfg_clk_div(cfg_clk_div),
    .cfg_single(cfg_single), .link_clk_in(link_clk_in), .link_clk_out(link_clk_out),
    .blink_clk_in(blink_clk_in), .blink_clk_out(blink_clk_out), .blink_clk_sel(blink_clk_sel),
    .start_in(start_in), .end_out(end_out), .dout(dout), .din(din),
    .tx_frame(tx_frame), .rx_frame(rx_frame), .rx_valid(rx_valid));

  // {tx pattern, divide value}
  localparam logic [19:0] VEC [0:5] = '{
    {12'hA5C, 8'd0}, {12'h001, 8'd1}, {12'h800, 8'd3},
    {12'hFFF, 8'd2}, {12'h000, 8'd5}, {12'h3C6, 8'd0}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_valid(input int n);
    int target;
    target = vcount + n;
    while (vcount < target) @(negedge clk);
  endtask

  // Length of the next high level of a sampled signal, in system cycles.
  task automatic high_len(input bit blink, output int len);
    while ((blink ? blink_clk_out : link_clk_out) !== 1'b0) @(negedge clk);
    while ((blink ? blink_clk_out : link_clk_out) !== 1'b1) @(negedge clk);
    len = 0;
    do begin @(negedge clk); len++; end
    while ((blink ? blink_clk_out : link_clk_out) === 1'b1);
  endtask

  // One received link period: fall, sample, set din, rise.
  task automatic ext_cycle(input logic dbit, output logic s_dout, output logic s_end);
    link_clk_in = 1'b0;
    repeat (EXTH) @(negedge clk);
    s_dout = dout; s_end = end_out;
    din_drv = dbit;
    link_clk_in = 1'b1;
    repeat (EXTH) @(negedge clk);
  endtask

  initial begin
    logic [19:0] v;
    logic sd, se;
    int len, t0, vc0;
    logic [N-1:0] rxp;

    // R1: reset state
    cfg_clk_src = 1'b1; cfg_clk_div = 8'd3; tx_frame = 12'hFFF;
    repeat (3) @(negedge clk);
    chk({link_clk_out, blink_clk_out, dout, end_out, rx_valid} == 5'b0, "R1 reset outputs",
        {link_clk_out, blink_clk_out, dout, end_out, rx_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({link_clk_out, blink_clk_out, dout, end_out, rx_valid} == 5'b0 && rx_frame == '0,
        "R1 first cycle after reset", {link_clk_out, rx_frame}, 0);

    // R4: blink period
    high_len(1'b1, len);
    chk(len == SHZ, "R4 blink level length", len, SHZ);
    chk(blink_clk_sel == blink_clk_out, "R4 blink select", blink_clk_sel, blink_clk_out);

    // Vector table: R2 level length and R6/R8/R9 loopback capture in single mode
    loop_en = 1'b1; cfg_single = 1'b1;
    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      tx_frame = v[19:8]; cfg_clk_div = v[7:0];
      wait_valid(2);
      chk(last_rx == v[19:8], "R6 R8 loopback frame", last_rx, v[19:8]);
      high_len(1'b0, len);
      chk(len == int'(v[7:0]) + 1, "R2 link level length", len, int'(v[7:0]) + 1);
    end

    // R9: frame period with start_in low, then high (ignored)
    cfg_clk_div = 8'd2;
    wait_valid(1); t0 = vtime; wait_valid(1);
    chk(vtime - t0 == N * 2 * 3, "R9 frame period start low", vtime - t0, N * 6);
    start_in = 1'b1;
    wait_valid(1); t0 = vtime; wait_valid(1);
    chk(vtime - t0 == N * 2 * 3, "R9 frame period start high", vtime - t0, N * 6);
    start_in = 1'b0;

    // R3: received clocks
    cfg_clk_src = 1'b0; cfg_single = 1'b0; loop_en = 1'b0;
    do_reset();
    begin
      bit quiet;
      quiet = 1'b1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (link_clk_out || blink_clk_out) quiet = 1'b0;
      end
      chk(quiet, "R3 generated clocks quiet", quiet, 1);
    end
    blink_clk_in = 1'b1; @(negedge clk);
    chk(blink_clk_sel == 1'b1, "R3 blink follows input high", blink_clk_sel, 1);
    blink_clk_in = 1'b0; @(negedge clk);
    chk(blink_clk_sel == 1'b0, "R3 blink follows input low", blink_clk_sel, 0);

    // R5: no start, no frame
    vc0 = vcount;
    for (int k = 0; k < 3; k++) begin
      ext_cycle(1'b1, sd, se);
      chk(sd == 1'b0 && se == 1'b0, "R5 idle without start", {sd, se}, 0);
    end
    repeat (EXTH) @(negedge clk);
    chk(vcount == vc0, "R5 no capture without start", vcount - vc0, 0);

    // R5 R6 R7 R8: externally started frame on a received clock
    tx_frame = 12'hB36; rxp = 12'h6C9; vc0 = vcount;
    start_in = 1'b1;
    ext_cycle(1'b0, sd, se);
    start_in = 1'b0;
    for (int k = 0; k < N; k++) begin
      ext_cycle(rxp[N-1-k], sd, se);
      chk(sd == tx_frame[N-1-k], "R6 bit order msb first", sd, tx_frame[N-1-k]);
      chk(se == (k == N-1), "R7 end strobe on last bit", se, (k == N-1));
    end
    chk(vcount == vc0 + 1, "R8 single valid pulse", vcount - vc0, 1);
    chk(last_rx == rxp, "R8 captured frame", last_rx, rxp);
    ext_cycle(1'b0, sd, se);
    chk(se == 1'b0 && sd == 1'b0, "R7 end strobe clears", {sd, se}, 0);
    chk(rx_frame == rxp, "R8 frame holds", rx_frame, rxp);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule